// File: doc/BRIEF.md
# Branch Target and Condition Unit

This block resolves the control-flow opcodes of a small 8-bit controller core. For each instruction handed to it, it decides whether the flow changes and what the next program counter is. It covers conditional jumps within the current page, jumps on a single accumulator bit, decrement-and-loop on a working register, long jumps and calls, and the indirect jump through a table byte in the current page. Opcodes that are not control-flow opcodes pass through as not taken, with the next program counter equal to the sequential address.

The core presents one instruction per transfer on a valid/ready input. The transfer carries the opcode, the operand byte, the sequential next address, the accumulator, the flags and pins, the current value of the working register a loop opcode names, and the table byte for the indirect jump. The result appears one cycle after acceptance on a valid/ready output and is held there until it is taken. An input transfer happens when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. While a result waits with `out_ready` low, the output fields stay unchanged and no new instruction is accepted.

The unit also holds the one-bit memory bank register. Long jump and call targets draw their top address bit from this register.

Top module: `branch_resolve_unit`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and `mem_bank` is 0.
- R2: An opcode with low nibble 6 is a conditional jump when its high nibble names a condition. The conditions are: 1 timer flag set, 2 T0 low, 3 T0 high, 4 T1 low, 5 T1 high, 7 F1 set, 8 interrupt pin high (inactive, the pin is active low), 9 accumulator nonzero, 11 F0 set, 12 accumulator zero, 14 carry clear, 15 carry set. `out_taken` equals the named condition. High nibbles 0, 6, 10 and 13 with low nibble 6 are not branches.
- R3: Conditional, bit-test and loop jumps have the target {next-address bits 11:8, operand byte}, so the page comes from the sequential address even when that address has crossed into a new page.
- R4: An opcode with low nibble 2 and bit 4 set is a bit-test jump. It is taken exactly when accumulator bit opcode[7:5] is 1.
- R5: An opcode with low nibble 4 is always taken, with target {mem_bank, opcode[7:5], operand}. `out_is_call` is 1 when opcode bit 4 is 1 and 0 when it is 0.
- R6: Opcodes 0xE8 to 0xEF decrement register opcode[2:0]. `out_reg_we` is 1, `out_reg_idx` is opcode[2:0], `out_reg_val` is the input register value minus 1 modulo 256, and the jump is taken exactly when that result is nonzero.
- R7: Opcode 0xB3 is always taken, with target {next-address bits 11:8, table byte}.
- R8: Opcode 0xE5 clears `mem_bank` and 0xF5 sets it, taking effect on the cycle after acceptance. Neither is a branch. A select opcode that is presented but not accepted has no effect.
- R9: When `out_taken` is 0, `out_next_pc` equals the sequential address. When `out_taken` is 1, it equals `out_target`. For non-branch opcodes `out_branch`, `out_taken` and `out_reg_we` are 0.
- R10: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and every output field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction accepted this cycle if valid |
| in_opcode | input | 8 | Opcode byte |
| in_operand | input | 8 | Second instruction byte |
| in_next_pc | input | 12 | Address of the next sequential instruction |
| in_acc | input | 8 | Accumulator |
| in_carry | input | 1 | Carry flag |
| in_f0 | input | 1 | User flag 0 |
| in_f1 | input | 1 | User flag 1 |
| in_t0 | input | 1 | Test pin 0 |
| in_t1 | input | 1 | Test pin 1 |
| in_int_n | input | 1 | External interrupt pin, active low |
| in_timer_flag | input | 1 | Timer overflow flag |
| in_reg_val | input | 8 | Current value of the register named by opcode[2:0] |
| in_table_byte | input | 8 | Byte read from the current page at offset A |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result consumed this cycle if valid |
| out_branch | output | 1 | Opcode is a control-flow opcode |
| out_taken | output | 1 | Flow changes |
| out_is_call | output | 1 | Opcode is a call |
| out_target | output | 12 | Computed branch target |
| out_next_pc | output | 12 | Resolved next program counter |
| out_reg_we | output | 1 | Loop register write-back request |
| out_reg_idx | output | 3 | Loop register index |
| out_reg_val | output | 8 | Decremented register value |
| mem_bank | output | 1 | Memory bank register |

## Verification
The bench builds the unit with its default widths: a 12-bit program counter and 8-bit data. At these widths the whole opcode space can be drawn at random, and page-end next addresses such as 0x100 and 0xFFF can be reached directly. Random stalls on `out_ready` are mixed with bank-select opcodes that are offered while the unit is stalled, to show that refused selects leave the bank alone. Directed cases cover loop registers at 1 and 0, where the decremented value is 0 and 0xFF.

// File: rtl/bru_pkg.sv
package bru_pkg;
  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_COND = 3'd1,
    K_BIT  = 3'd2,
    K_JMP  = 3'd3,
    K_CALL = 3'd4,
    K_LOOP = 3'd5,
    K_IND  = 3'd6,
    K_SEL  = 3'd7
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [3:0] cond;
    logic [2:0] sel3;
    logic       sel_val;
  } dec_t;

  localparam logic [7:0] OP_IND = 8'hB3;
endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
(
  input  logic [7:0] opcode,
  output dec_t       dec
);
  logic [3:0] hi;
  logic [3:0] lo;
  logic       cond_ok;

  assign hi = opcode[7:4];
  assign lo = opcode[3:0];

  always_comb begin
    case (hi)
      4'd0, 4'd6, 4'd10, 4'd13: cond_ok = 1'b0;
      default:                  cond_ok = 1'b1;
    endcase
  end

  always_comb begin
    dec.kind    = K_NONE;
    dec.cond    = hi;
    dec.sel3    = opcode[7:5];
    dec.sel_val = opcode[4];
    if (opcode == OP_IND) begin
      dec.kind = K_IND;
    end else if (lo == 4'h4) begin
      dec.kind = opcode[4] ? K_CALL : K_JMP;
    end else if (lo == 4'h6 && cond_ok) begin
      dec.kind = K_COND;
    end else if (lo == 4'h2 && opcode[4]) begin
      dec.kind = K_BIT;
    end else if (hi == 4'hE && opcode[3]) begin
      dec.kind = K_LOOP;
      dec.sel3 = opcode[2:0];
    end else if (lo == 4'h5 && hi[3:1] == 3'b111) begin
      dec.kind = K_SEL;
    end
  end
endmodule

// File: rtl/bru_cond_eval.sv
module bru_cond_eval #(
  parameter int DATA_W = 8
) (
  input  logic [3:0]        cond,
  input  logic [DATA_W-1:0] acc,
  input  logic              carry,
  input  logic              f0,
  input  logic              f1,
  input  logic              t0,
  input  logic              t1,
  input  logic              int_n,
  input  logic              timer_flag,
  output logic              hit
);
  logic acc_zero;
  assign acc_zero = (acc == '0);

  always_comb begin
    case (cond)
      4'd1:    hit = timer_flag;
      4'd2:    hit = ~t0;
      4'd3:    hit = t0;
      4'd4:    hit = ~t1;
      4'd5:    hit = t1;
      4'd7:    hit = f1;
      4'd8:    hit = int_n;
      4'd9:    hit = ~acc_zero;
      4'd11:   hit = f0;
      4'd12:   hit = acc_zero;
      4'd14:   hit = ~carry;
      4'd15:   hit = carry;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/bru_target_gen.sv
module bru_target_gen
  import bru_pkg::*;
#(
  parameter int PC_W   = 12,
  parameter int DATA_W = 8
) (
  input  dec_t              dec,
  input  logic              cond_hit,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] table_byte,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [PC_W-1:0]   next_pc,
  input  logic              bank,
  output logic              branch,
  output logic              taken,
  output logic              is_call,
  output logic [PC_W-1:0]   target,
  output logic [PC_W-1:0]   resolved_pc,
  output logic              reg_we,
  output logic [2:0]        reg_idx,
  output logic [DATA_W-1:0] reg_new
);
  localparam int PAGE_W = PC_W - DATA_W;

  logic [PC_W-1:0]   short_t;
  logic [PC_W-1:0]   long_t;
  logic [PC_W-1:0]   ind_t;
  logic [DATA_W-1:0] dec_val;

  assign short_t = {next_pc[PC_W-1:DATA_W], operand};
  assign ind_t   = {next_pc[PC_W-1:DATA_W], table_byte};
  assign long_t  = PC_W'({bank, dec.sel3, operand});
  assign dec_val = reg_val - DATA_W'(1);

  always_comb begin
    branch  = 1'b1;
    taken   = 1'b0;
    is_call = 1'b0;
    target  = short_t;
    reg_we  = 1'b0;
    reg_idx = dec.sel3;
    reg_new = dec_val;
    unique case (dec.kind)
      K_COND: taken = cond_hit;
      K_BIT:  taken = acc[dec.sel3];
      K_JMP: begin
        taken  = 1'b1;
        target = long_t;
      end
      K_CALL: begin
        taken   = 1'b1;
        is_call = 1'b1;
        target  = long_t;
      end
      K_LOOP: begin
        reg_we = 1'b1;
        taken  = (dec_val != '0);
      end
      K_IND: begin
        taken  = 1'b1;
        target = ind_t;
      end
      default: branch = 1'b0;
    endcase
    resolved_pc = taken ? target : next_pc;
  end

  if (PAGE_W < 1) begin : g_bad_width
    initial $error("PC_W must exceed DATA_W");
  end
endmodule

// File: rtl/bru_out_stage.sv
module bru_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import bru_pkg::*;
#(
  parameter int PC_W   = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_opcode,
  input  logic [DATA_W-1:0] in_operand,
  input  logic [PC_W-1:0]   in_next_pc,
  input  logic [DATA_W-1:0] in_acc,
  input  logic              in_carry,
  input  logic              in_f0,
  input  logic              in_f1,
  input  logic              in_t0,
  input  logic              in_t1,
  input  logic              in_int_n,
  input  logic              in_timer_flag,
  input  logic [DATA_W-1:0] in_reg_val,
  input  logic [DATA_W-1:0] in_table_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_branch,
  output logic              out_taken,
  output logic              out_is_call,
  output logic [PC_W-1:0]   out_target,
  output logic [PC_W-1:0]   out_next_pc,
  output logic              out_reg_we,
  output logic [2:0]        out_reg_idx,
  output logic [DATA_W-1:0] out_reg_val,
  output logic              mem_bank
);
  localparam int PAY_W = 4 + 2 * PC_W + 1 + 3 + DATA_W;

  dec_t              dec;
  logic              cond_hit;
  logic              c_branch, c_taken, c_call, c_we;
  logic [PC_W-1:0]   c_target, c_pc;
  logic [2:0]        c_idx;
  logic [DATA_W-1:0] c_val;
  logic [PAY_W-1:0]  pay_in, pay_out;
  logic              bank_q;
  logic              accept;

  bru_decode u_decode (
    .opcode (in_opcode),
    .dec    (dec)
  );

  bru_cond_eval #(.DATA_W(DATA_W)) u_cond (
    .cond       (dec.cond),
    .acc        (in_acc),
    .carry      (in_carry),
    .f0         (in_f0),
    .f1         (in_f1),
    .t0         (in_t0),
    .t1         (in_t1),
    .int_n      (in_int_n),
    .timer_flag (in_timer_flag),
    .hit        (cond_hit)
  );

  bru_target_gen #(.PC_W(PC_W), .DATA_W(DATA_W)) u_target (
    .dec         (dec),
    .cond_hit    (cond_hit),
    .acc         (in_acc),
    .operand     (in_operand),
    .table_byte  (in_table_byte),
    .reg_val     (in_reg_val),
    .next_pc     (in_next_pc),
    .bank        (bank_q),
    .branch      (c_branch),
    .taken       (c_taken),
    .is_call     (c_call),
    .target      (c_target),
    .resolved_pc (c_pc),
    .reg_we      (c_we),
    .reg_idx     (c_idx),
    .reg_new     (c_val)
  );

  assign pay_in = {c_branch, c_taken, c_call, c_we, c_target, c_pc, 1'b0, c_idx, c_val};

  bru_out_stage #(.W(PAY_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  logic unused_pad;
  assign {out_branch, out_taken, out_is_call, out_reg_we, out_target, out_next_pc,
          unused_pad, out_reg_idx, out_reg_val} = pay_out;

  assign accept = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)                          bank_q <= 1'b0;
    else if (accept && dec.kind == K_SEL) bank_q <= dec.sel_val;
  end

  assign mem_bank = bank_q;
endmodule

// File: rtl/branch_resolve_unit_chk.sv
module branch_resolve_unit_chk #(
  parameter int PC_W   = 12,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [7:0]        in_opcode,
  input logic [PC_W-1:0]   in_next_pc,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_branch,
  input logic              out_taken,
  input logic              out_is_call,
  input logic [PC_W-1:0]   out_target,
  input logic [PC_W-1:0]   out_next_pc,
  input logic              out_reg_we,
  input logic [DATA_W-1:0] out_reg_val,
  input logic              mem_bank
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_next_pc) && $stable(out_taken) && $stable(out_target)); // R10
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R10
  AST_TAKEN_PC: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_taken |-> out_next_pc == out_target); // R9
  AST_NONBRANCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_branch |-> !out_taken && !out_reg_we); // R9
  AST_CALL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_call |-> out_taken); // R5
  AST_LOOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_reg_we |-> out_taken == (out_reg_val != '0)); // R6
  AST_BANK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_opcode == 8'hF5 |=> mem_bank); // R8
  AST_BANK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_opcode == 8'hE5 |=> !mem_bank); // R8
  AST_SHORT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_opcode[3:0] == 4'h6 |=>
      out_target[PC_W-1:DATA_W] == $past(in_next_pc[PC_W-1:DATA_W])); // R3
endmodule

bind branch_resolve_unit branch_resolve_unit_chk #(.PC_W(PC_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_opcode   (in_opcode),
  .in_next_pc  (in_next_pc),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_branch  (out_branch),
  .out_taken   (out_taken),
  .out_is_call (out_is_call),
  .out_target  (out_target),
  .out_next_pc (out_next_pc),
  .out_reg_we  (out_reg_we),
  .out_reg_val (out_reg_val),
  .mem_bank    (mem_bank)
);

// File: tb/branch_resolve_unit_tb.sv
module branch_resolve_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 12;
  localparam int DW   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_opcode = '0, in_operand = '0, in_acc = '0, in_reg_val = '0, in_table_byte = '0;
  logic [PC_W-1:0] in_next_pc = '0;
  logic in_carry = 0, in_f0 = 0, in_f1 = 0, in_t0 = 0, in_t1 = 0, in_int_n = 1, in_timer_flag = 0;
  logic out_valid, out_ready = 1'b0;
  logic out_branch, out_taken, out_is_call, out_reg_we, mem_bank;
  logic [PC_W-1:0] out_target, out_next_pc;
  logic [2:0] out_reg_idx;
  logic [7:0] out_reg_val;

  int checks = 0;
  int errors = 0;
  logic bank_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_resolve_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_operand(in_operand), .in_next_pc(in_next_pc),
    .in_acc(in_acc), .in_carry(in_carry), .in_f0(in_f0), .in_f1(in_f1),
    .in_t0(in_t0), .in_t1(in_t1), .in_int_n(in_int_n), .in_timer_flag(in_timer_flag),
    .in_reg_val(in_reg_val), .in_table_byte(in_table_byte),
    .out_valid(out_valid), .out_ready(out_ready), .out_branch(out_branch),
    .out_taken(out_taken), .out_is_call(out_is_call), .out_target(out_target),
    .out_next_pc(out_next_pc), .out_reg_we(out_reg_we), .out_reg_idx(out_reg_idx),
    .out_reg_val(out_reg_val), .mem_bank(mem_bank)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected model built from the requirement text
  logic e_br, e_tk, e_call, e_we;
  logic [PC_W-1:0] e_tgt, e_pc;
  logic [7:0] e_val;
  string e_tag;

  function automatic logic cond_of(input logic [3:0] c);
    case (c)
      1: return in_timer_flag;
      2: return !in_t0;
      3: return in_t0;
      4: return !in_t1;
      5: return in_t1;
      7: return in_f1;
      8: return in_int_n;
      9: return in_acc != 0;
      11: return in_f0;
      12: return in_acc == 0;
      14: return !in_carry;
      15: return in_carry;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model();
    logic [3:0] hi = in_opcode[7:4];
    logic [3:0] lo = in_opcode[3:0];
    logic [PC_W-1:0] shrt = {in_next_pc[11:8], in_operand};
    e_br = 1; e_tk = 0; e_call = 0; e_we = 0; e_tgt = shrt; e_val = in_reg_val - 8'd1;
    if (in_opcode == 8'hB3) begin
      e_tag = "R7"; e_tk = 1; e_tgt = {in_next_pc[11:8], in_table_byte};
    end else if (lo == 4) begin
      e_tag = "R5"; e_tk = 1; e_call = in_opcode[4];
      e_tgt = {bank_m, in_opcode[7:5], in_operand};
    end else if (lo == 6 && !(hi inside {0, 6, 10, 13})) begin
      e_tag = "R2"; e_tk = cond_of(hi);
    end else if (lo == 2 && in_opcode[4]) begin
      e_tag = "R4"; e_tk = in_acc[in_opcode[7:5]];
    end else if (hi == 14 && in_opcode[3]) begin
      e_tag = "R6"; e_we = 1; e_tk = (e_val != 0);
    end else begin
      e_tag = "R9"; e_br = 0;
    end
    e_pc = e_tk ? e_tgt : in_next_pc;
  endtask

  task automatic txn(input int stall);
    logic [7:0] op_save;
    @(negedge clk);
    model();
    chk("R10 in_ready idle", in_ready, 1);
    in_valid = 1'b1;
    op_save = in_opcode;
    @(negedge clk);
    in_valid = 1'b0;
    if (op_save == 8'hE5) bank_m = 1'b0;
    if (op_save == 8'hF5) bank_m = 1'b1;
    chk("R10 out_valid", out_valid, 1);
    chk({e_tag, " branch"}, out_branch, e_br);
    chk({e_tag, " taken"}, out_taken, e_tk);
    chk({e_tag, " next_pc R9"}, out_next_pc, e_pc);
    chk({e_tag, " we"}, out_reg_we, e_we);
    if (e_br && e_tag != "R6") chk({e_tag, " target R3"}, out_target, e_tgt);
    if (e_tag == "R5") chk("R5 is_call", out_is_call, e_call);
    if (e_we) begin
      chk("R6 idx", out_reg_idx, op_save[2:0]);
      chk("R6 val", out_reg_val, e_val);
    end
    chk("R8 bank", mem_bank, bank_m);
    for (int i = 0; i < stall; i++) begin
      in_valid = 1'b1;
      in_opcode = bank_m ? 8'hE5 : 8'hF5;
      @(negedge clk);
      chk("R10 blocked", in_ready, 0);
      chk("R10 hold pc", out_next_pc, e_pc);
      chk("R8 refused select", mem_bank, bank_m);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R10 drained", out_valid, 0);
  endtask

  task automatic rand_inputs();
    in_operand = 8'($urandom); in_acc = 8'($urandom);
    in_next_pc = 12'($urandom); in_reg_val = 8'($urandom);
    in_table_byte = 8'($urandom);
    {in_carry, in_f0, in_f1, in_t0, in_t1, in_int_n, in_timer_flag} = 7'($urandom);
    if ($urandom_range(0, 5) == 0) in_acc = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 bank", mem_bank, 0);
    rst_n = 1'b1;
    // directed: every condition code, both polarities
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 2; p++) begin
        rand_inputs();
        {in_carry, in_f0, in_f1, in_t0, in_t1, in_int_n, in_timer_flag} = p ? 7'h7F : 7'h00;
        in_acc = p ? 8'h5A : 8'h00;
        in_opcode = 8'(c * 16 + 6);
        txn(0);
      end
    end
    // page boundary short jump (R3)
    rand_inputs(); in_opcode = 8'hF6; in_carry = 1; in_next_pc = 12'h100; in_operand = 8'h33; txn(0);
    // loop edges (R6)
    rand_inputs(); in_opcode = 8'hE9; in_reg_val = 8'h01; txn(1);
    rand_inputs(); in_opcode = 8'hEF; in_reg_val = 8'h00; txn(0);
    // bank select then long jump / call (R8, R5)
    rand_inputs(); in_opcode = 8'hF5; txn(2);
    rand_inputs(); in_opcode = 8'hE4; in_operand = 8'hC1; txn(0);
    rand_inputs(); in_opcode = 8'h74; txn(0);
    rand_inputs(); in_opcode = 8'hE5; txn(1);
    rand_inputs(); in_opcode = 8'h14; txn(0);
    // indirect (R7) and bit tests (R4)
    rand_inputs(); in_opcode = 8'hB3; in_next_pc = 12'hFFF; txn(0);
    rand_inputs(); in_opcode = 8'hF2; in_acc = 8'h80; txn(0);
    rand_inputs(); in_opcode = 8'h12; in_acc = 8'hFE; txn(0);
    // random
    for (int n = 0; n < 600; n++) begin
      rand_inputs();
      in_opcode = 8'($urandom);
      txn($urandom_range(0, 2));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule